// File: doc/BRIEF.md
# DRAM Refresh Controller with Address Multiplexer

This block keeps a 64K x 1 dynamic RAM array refreshed and shares its 8-bit multiplexed address bus between processor accesses and refresh. A free-running divider, sized from the input clock frequency, raises a refresh request 64,000 times per second, which is one request roughly every 15.6 us. Each request is served by a RAS-only cycle: the current refresh row goes onto the bus, RAS is pulsed and CAS stays high. An 8-bit row counter then moves to the next row.

With an 8-bit counter and one request every 15.6 us, the 256-step sweep takes 4 ms. Parts that need all 256 rows refreshed in 4 ms are covered. Parts that need 128 rows in 2 ms ignore bit 7 of the refresh address, so each of their rows is refreshed twice in every 4 ms. The same request rate that older 16K parts used is therefore kept, and one build serves both device types. A processor access puts the upper address byte on the bus while RAS falls. It then switches the bus to the lower byte before CAS falls. A refresh that comes due during a processor cycle waits until that cycle ends. After that it has priority over the next processor request, and the processor sees a wait indication while it runs.

Top module: `dram_rfsh_ctrl`

## Requirements
- R1: A refresh request is raised once every DIV = CLK_HZ/REQ_HZ clock cycles. With no processor traffic, the first refresh RAS fall comes in cycle DIV+2 after reset release, and each later one comes exactly DIV cycles after the one before.
- R2: A refresh cycle keeps CAS and WE high for its whole RAS-low period, so CAS falls only for processor accesses.
- R3: The refresh row starts at 0 after reset and increases by 1 after each completed refresh cycle. It wraps from 255 to 0, so over 256 refreshes each value of the low 7 bits appears exactly twice.
- R4: During refresh, RAS is low for exactly T_RAS cycles. Between any RAS rise and the next RAS fall, RAS stays high for at least T_RP cycles.
- R5: A processor access accepted at edge e shows the following, with cpu_addr bits [15:8] as the row and [7:0] as the column. At e the row is on the bus with RAS high. At e+1 RAS falls and the row stays on the bus. At e+2 the column is on the bus with RAS low and CAS high. At e+3 CAS goes low and stays low for T_CAS cycles. cpu_ack_o pulses in the last CAS-low cycle. RAS and CAS are then high for T_RP cycles. WE is low from e+2 through the last CAS-low cycle only for writes (cpu_we_i = 1).
- R6: A refresh that comes due during a processor cycle starts only after that cycle's precharge ends. When a refresh request and a processor request are both waiting in the idle state, refresh goes first, and cpu_wait_o is high for the whole refresh cycle.
- R7: If a second request arrives while the first is still waiting to be served, rfsh_overrun_o goes high and stays high until reset.
- R8: While reset is active and right after it, RAS, CAS and WE are high, the address bus is 0, and cpu_ack_o, cpu_wait_o and rfsh_overrun_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor access request, held until acknowledged |
| cpu_we_i | input | 1 | Processor access is a write |
| cpu_addr_i | input | 2*AW | Processor address: row in the upper half, column in the lower half |
| cpu_ack_o | output | 1 | One-cycle pulse when the processor access completes |
| cpu_wait_o | output | 1 | High while a refresh cycle holds the bus |
| dram_addr_o | output | AW | Multiplexed DRAM address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| rfsh_overrun_o | output | 1 | Sticky error: a refresh request was lost |

## Verification
A wrong row count is visible on the bus at the next refresh RAS fall, so it shows within one request period. A skipped or repeated row breaks the twice-per-sweep pattern of the low 7 bits over one 256-refresh sweep. A divider or pending-flag fault moves the RAS fall cycle by at least one clock, and that shift is measured from reset and from the fall before. Arbitration faults change the cycle of a RAS fall or an acknowledge during overlap. An overrun flag that fails to hold is seen on the next sample.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_C_SETUP,
    ST_C_RAS,
    ST_C_COL,
    ST_C_CAS,
    ST_C_PRE,
    ST_R_SETUP,
    ST_R_RAS,
    ST_R_PRE
  } ctrl_state_e;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_ROW,
    SEL_COL,
    SEL_RFSH
  } addr_sel_e;

endpackage

// File: rtl/rfsh_tick_gen.sv
module rfsh_tick_gen #(
  parameter int unsigned DIV = 1953
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV < 2) begin : g_every
      logic unused_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) unused_q <= 1'b0;
        else         unused_q <= 1'b1;
      end
      assign tick_o = unused_q;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(DIV - 1));

      a_r1_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/rfsh_req_track.sv
module rfsh_req_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic done_i,
  output logic pend_o,
  output logic overrun_o
);
  logic pend_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (tick_i)      pend_q <= 1'b1;
      else if (done_i) pend_q <= 1'b0;
      // second request while the first is still unserved
      if (tick_i && pend_q && !done_i) ovr_q <= 1'b1;
    end
  end

  assign pend_o    = pend_q;
  assign overrun_o = ovr_q;

  a_r7_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> ovr_q);
  a_r7_pend_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !done_i) |=> pend_q);
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] row_o
);
  logic [W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_q <= '0;
    else if (adv_i) row_q <= row_q + 1'b1;
  end

  assign row_o = row_q;
endmodule

// File: rtl/rfsh_addr_mux.sv
module rfsh_addr_mux
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  addr_sel_e         sel_i,
  input  logic [2*AW-1:0]   cpu_addr_i,
  input  logic [AW-1:0]     rfsh_row_i,
  output logic [AW-1:0]     addr_o
);
  always_comb begin
    unique case (sel_i)
      SEL_ROW:  addr_o = cpu_addr_i[2*AW-1:AW];
      SEL_COL:  addr_o = cpu_addr_i[AW-1:0];
      SEL_RFSH: addr_o = rfsh_row_i;
      default:  addr_o = '0;
    endcase
  end
endmodule

// File: rtl/dram_rfsh_ctrl.sv
module dram_rfsh_ctrl
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned CLK_HZ = 125_000_000,
  parameter int unsigned REQ_HZ = 64_000,
  parameter int unsigned AW     = 8,
  parameter int unsigned T_RAS  = 4,
  parameter int unsigned T_CAS  = 2,
  parameter int unsigned T_RP   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cpu_req_i,
  input  logic            cpu_we_i,
  input  logic [2*AW-1:0] cpu_addr_i,
  output logic            cpu_ack_o,
  output logic            cpu_wait_o,
  output logic [AW-1:0]   dram_addr_o,
  output logic            dram_ras_no,
  output logic            dram_cas_no,
  output logic            dram_we_no,
  output logic            rfsh_overrun_o
);
  localparam int unsigned DIV  = CLK_HZ / REQ_HZ;
  localparam int unsigned TM1  = (T_RAS > T_CAS) ? T_RAS : T_CAS;
  localparam int unsigned TMAX = (TM1 > T_RP) ? TM1 : T_RP;
  localparam int unsigned CW   = $clog2(TMAX + 1);

  ctrl_state_e     state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [2*AW-1:0] addr_q;
  logic            we_q;
  logic            tick, pend, rfsh_done, accept;
  logic [AW-1:0]   rfsh_row;
  addr_sel_e       sel;

  rfsh_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  rfsh_req_track u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .done_i   (rfsh_done),
    .pend_o   (pend),
    .overrun_o(rfsh_overrun_o)
  );

  rfsh_row_ctr #(.W(AW)) u_row (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (rfsh_done),
    .row_o (rfsh_row)
  );

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    rfsh_done = 1'b0;
    accept    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pend) begin
          state_d = ST_R_SETUP;
        end else if (cpu_req_i) begin
          state_d = ST_C_SETUP;
          accept  = 1'b1;
        end
      end
      ST_C_SETUP: state_d = ST_C_RAS;
      ST_C_RAS:   state_d = ST_C_COL;
      ST_C_COL: begin
        state_d = ST_C_CAS;
        cnt_d   = CW'(T_CAS - 1);
      end
      ST_C_CAS: begin
        if (cnt_q == '0) begin
          state_d = ST_C_PRE;
          cnt_d   = CW'(T_RP - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_R_SETUP: begin
        state_d = ST_R_RAS;
        cnt_d   = CW'(T_RAS - 1);
      end
      ST_R_RAS: begin
        if (cnt_q == '0) begin
          state_d   = ST_R_PRE;
          cnt_d     = CW'(T_RP - 1);
          rfsh_done = 1'b1;
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_C_PRE, ST_R_PRE: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (accept) begin
        addr_q <= cpu_addr_i;
        we_q   <= cpu_we_i;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_C_SETUP, ST_C_RAS: sel = SEL_ROW;
      ST_C_COL, ST_C_CAS:   sel = SEL_COL;
      ST_R_SETUP, ST_R_RAS: sel = SEL_RFSH;
      default:              sel = SEL_NONE;
    endcase
  end

  rfsh_addr_mux #(.AW(AW)) u_mux (
    .sel_i     (sel),
    .cpu_addr_i(addr_q),
    .rfsh_row_i(rfsh_row),
    .addr_o    (dram_addr_o)
  );

  assign dram_ras_no = !(state_q inside {ST_C_RAS, ST_C_COL, ST_C_CAS, ST_R_RAS});
  assign dram_cas_no = (state_q != ST_C_CAS);
  assign dram_we_no  = !(we_q && (state_q inside {ST_C_COL, ST_C_CAS}));
  assign cpu_ack_o   = (state_q == ST_C_CAS) && (cnt_q == '0);
  assign cpu_wait_o  = state_q inside {ST_R_SETUP, ST_R_RAS, ST_R_PRE};

  a_r5_row_held_at_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> $stable(dram_addr_o));
  a_r5_col_held_at_cas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) |-> ($stable(dram_addr_o) && !dram_ras_no));
  a_r3_row_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_done |=> (rfsh_row == $past(rfsh_row) + AW'(1)));
  a_r6_cpu_not_cut: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_C_SETUP, ST_C_RAS, ST_C_COL, ST_C_CAS, ST_C_PRE})
      |=> !(state_q inside {ST_R_SETUP, ST_R_RAS, ST_R_PRE}));
  a_r6_wait_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_wait_o |-> !cpu_ack_o);
  a_r2_rfsh_cas_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfsh_done || cpu_wait_o) |-> (dram_cas_no && dram_we_no));
endmodule

// File: tb/sim_dram_rfsh_ctrl.sv
module sim_dram_rfsh_ctrl;
  localparam int unsigned T_RAS = 3;
  localparam int unsigned T_CAS = 2;
  localparam int unsigned T_RP  = 2;
  localparam int unsigned DIV   = 40;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic ack, wt, ras_n, cas_n, we_n, ovr;
  logic [7:0] addr;
  logic ack1, wt1, ras1, cas1, we1, ovr1;
  logic [7:0] addr1;

  always #4ns clk = ~clk;

  dram_rfsh_ctrl #(.CLK_HZ(64_000 * DIV), .REQ_HZ(64_000), .AW(8),
                   .T_RAS(T_RAS), .T_CAS(T_CAS), .T_RP(T_RP)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_req_i(cpu_req), .cpu_we_i(cpu_we),
    .cpu_addr_i(cpu_addr), .cpu_ack_o(ack), .cpu_wait_o(wt),
    .dram_addr_o(addr), .dram_ras_no(ras_n), .dram_cas_no(cas_n),
    .dram_we_no(we_n), .rfsh_overrun_o(ovr));

  // request period shorter than one refresh cycle: forces overrun
  dram_rfsh_ctrl #(.CLK_HZ(64_000 * 4), .REQ_HZ(64_000), .AW(8),
                   .T_RAS(T_RAS), .T_CAS(T_CAS), .T_RP(T_RP)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_req_i(1'b0), .cpu_we_i(1'b0),
    .cpu_addr_i(16'h0), .cpu_ack_o(ack1), .cpu_wait_o(wt1),
    .dram_addr_o(addr1), .dram_ras_no(ras1), .dram_cas_no(cas1),
    .dram_we_no(we1), .rfsh_overrun_o(ovr1));

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  // bus monitor on u0, sampled at falling edges
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  int fall_t = 0, last_rise_t = -100, last_fall_t = 0, min_gap = 1000;
  logic [7:0] fall_addr = '0;
  bit saw_cas = 1'b0, saw_we = 1'b0;
  int rf_cnt = 0, rf_fall_last = 0, rf_seq_err = 0, rf_width_err = 0, rf_we_err = 0;
  int cas_fall_cnt = 0;
  int rf_fall [0:2];
  logic [7:0] rf_addr [0:2];
  int hist [0:127];

  initial begin
    for (int i = 0; i < 128; i++) hist[i] = 0;
    for (int i = 0; i < 3; i++) begin rf_fall[i] = 0; rf_addr[i] = '0; end
  end

  always @(negedge clk) if (rst_ni) begin
    prev_ras <= ras_n;
    prev_cas <= cas_n;
    if (prev_cas && !cas_n) cas_fall_cnt <= cas_fall_cnt + 1;
    if (prev_ras && !ras_n) begin
      fall_t      <= cyc;
      last_fall_t <= cyc;
      fall_addr   <= addr;
      saw_cas     <= !cas_n;
      saw_we      <= !we_n;
      if (cyc - last_rise_t < min_gap) min_gap <= cyc - last_rise_t;
    end else if (!ras_n) begin
      if (!cas_n) saw_cas <= 1'b1;
      if (!we_n)  saw_we  <= 1'b1;
    end
    if (!prev_ras && ras_n) begin
      last_rise_t <= cyc;
      if (!saw_cas) begin
        rf_cnt       <= rf_cnt + 1;
        rf_fall_last <= fall_t;
        if (rf_cnt < 3) begin rf_fall[rf_cnt] <= fall_t; rf_addr[rf_cnt] <= fall_addr; end
        if (rf_cnt < 256) hist[fall_addr[6:0]] <= hist[fall_addr[6:0]] + 1;
        if (fall_addr != rf_cnt[7:0]) rf_seq_err <= rf_seq_err + 1;
        if (cyc - fall_t != T_RAS) rf_width_err <= rf_width_err + 1;
        if (saw_we) rf_we_err <= rf_we_err + 1;
      end
    end
  end

  task automatic wait_rfsh_end();
    int n = rf_cnt;
    while (rf_cnt == n) @(negedge clk);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc != c) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R8 ras in reset", ras_n, 1);
    chk("R8 cas/we in reset", {cas_n, we_n}, 2'b11);
    chk("R8 addr in reset", addr, 0);
    chk("R8 ack/wait/ovr in reset", {ack, wt, ovr, ovr1}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R8 idle after reset", {ras_n, cas_n, we_n, ack, wt, addr}, {3'b111, 2'b00, 8'h00});
  endtask

  task automatic t_idle();
    while (rf_cnt < 3) @(negedge clk);
    chk("R1 first refresh fall", rf_fall[0], DIV + 2);
    chk("R1 second refresh fall", rf_fall[1], 2 * DIV + 2);
    chk("R1 third refresh fall", rf_fall[2], 3 * DIV + 2);
    chk("R3 first rows", {rf_addr[0], rf_addr[1], rf_addr[2]}, 24'h000102);
    chk("R2 no cas without cpu", cas_fall_cnt, 0);
  endtask

  task automatic t_rfsh_shape();
    chk("R4 ras width", rf_width_err, 0);
    chk("R4 precharge gap", (min_gap >= T_RP), 1);
    chk("R2 we high in refresh", rf_we_err, 0);
  endtask

  task automatic t_cpu(input logic [15:0] a, input logic w);
    wait_rfsh_end();
    repeat (3) @(negedge clk);
    cpu_addr = a; cpu_we = w; cpu_req = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      logic [11:0] exp_v;
      logic [7:0]  ea;
      @(negedge clk);
      ea = (i <= 2) ? a[15:8] : (i <= 5) ? a[7:0] : 8'h00;
      exp_v = {ea, (i >= 2 && i <= 5) ? 1'b0 : 1'b1, (i == 4 || i == 5) ? 1'b0 : 1'b1,
               (w && i >= 3 && i <= 5) ? 1'b0 : 1'b1, (i == 5)};
      chk($sformatf("R5 cpu step %0d addr/ras/cas/we/ack", i),
          {addr, ras_n, cas_n, we_n, ack}, exp_v);
      if (i == 5) cpu_req = 1'b0;
    end
  endtask

  task automatic t_collide_busy();
    int f, ack_t;
    wait_rfsh_end();
    f = rf_fall_last;
    wait_cyc(f + 35);
    cpu_addr = 16'h1234; cpu_we = 1'b0; cpu_req = 1'b1;
    do @(negedge clk); while (!ack);
    ack_t = cyc;
    cpu_req = 1'b0;
    chk("R6 cpu finishes unbroken", ack_t, f + 40);
    wait_rfsh_end();
    chk("R6 refresh deferred to after precharge", rf_fall_last, f + 45);
  endtask

  task automatic t_collide_prio();
    int f, ack_t;
    wait_rfsh_end();
    f = rf_fall_last;
    wait_cyc(f + 38);
    cpu_addr = 16'hC3F0; cpu_we = 1'b1; cpu_req = 1'b1;
    @(negedge clk);
    chk("R6 wait raised on refresh win", {wt, ras_n, addr}, {2'b11, 8'(rf_cnt)});
    repeat (5) begin
      @(negedge clk);
      chk("R6 wait held through refresh", wt, 1);
    end
    do @(negedge clk); while (!ack);
    ack_t = cyc;
    cpu_req = 1'b0;
    chk("R6 refresh first", rf_fall_last, f + 40);
    chk("R6 cpu ras after refresh", last_fall_t, f + 47);
    chk("R6 cpu ack after refresh", ack_t, f + 50);
  endtask

  task automatic t_sweep();
    int bad = 0;
    while (rf_cnt < 260) @(negedge clk);
    chk("R3 row sequence incl. wrap", rf_seq_err, 0);
    for (int i = 0; i < 128; i++) if (hist[i] != 2) bad++;
    chk("R3 low 7 bits twice per sweep", bad, 0);
    chk("R4 ras width over sweep", rf_width_err, 0);
    chk("R4 precharge gap over sweep", (min_gap >= T_RP), 1);
    chk("R2 cas falls only for cpu", cas_fall_cnt, 4);
  endtask

  task automatic t_overrun();
    chk("R7 no overrun at normal rate", ovr, 0);
    chk("R7 overrun at fast rate", ovr1, 1);
    repeat (10) @(negedge clk);
    chk("R7 overrun stays set", ovr1, 1);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_rfsh_shape();
    t_cpu(16'hA53C, 1'b1);
    t_cpu(16'h0FF0, 1'b0);
    t_collide_busy();
    t_collide_prio();
    t_sweep();
    t_overrun();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8ns * 150_000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished (cycle %0d)", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule